// File: doc/BRIEF.md
# Cascadable Latched Serial Status Register

This block lets a microcontroller read a group of already-filtered input states over a three-wire synchronous link. A high-to-low transition on the active-low latch strobe copies the parallel status word into an internal shift register. Each rising edge of the serial clock then moves the word one place toward the serial output. The output is active-low: a stored 1 drives the pin low.

The serial extension input takes bits from the previous device in a chain, and it uses the same active-low encoding as the output. Tying each device's serial output to the next device's extension input makes any number of devices behave as one long register. The controller reads that register from the serial output of the last device.

Two clear requests, undervoltage and an external reset, act as level inputs. Either one empties the register and holds the output at its inactive high level while it is asserted. The latch strobe, the serial clock and the extension input are brought into the system clock domain through synchroniser stages and then edge-detected.

Top module: `serial_status_reg`

## Requirements
- R1: After `rst_ni` is released, `ser_out_no` is high and the register holds all zeros.
- R2: A falling edge on `load_ni` copies `state_i` into the register. A rising edge on `load_ni` leaves the register unchanged.
- R3: Each rising edge of `sclk_i` shifts the register by exactly one position toward the output. A falling edge of `sclk_i` does not shift it.
- R4: `ser_out_no` is the inverse of register bit WIDTH-1, so a stored 1 reads as low. Right after a load, `state_i[WIDTH-1]` is presented first, followed by the lower bits in descending order.
- R5: On each shift, the inverse of `ser_in_ni` enters at bit 0. A high or unconnected extension input shifts in a 0.
- R6: When `ser_out_no` of one device feeds `ser_in_ni` of a second device and both share the latch and clock, the second device's output gives its own word, then the first device's word, then the first device's extension bits.
- R7: While `uv_i` or `ext_rst_i` is high, `ser_out_no` is high and load and shift strobes are ignored. After the request is released, the register is all zeros.
- R8: When a latch falling edge and a clock rising edge are detected in the same system cycle, the load wins and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_i | input | 1 | Undervoltage clear request, active high |
| ext_rst_i | input | 1 | External clear request, active high |
| state_i | input | WIDTH | Filtered parallel status word |
| load_ni | input | 1 | Latch strobe, active on falling edge |
| sclk_i | input | 1 | Serial shift clock, active on rising edge |
| ser_in_ni | input | 1 | Serial extension input, active low |
| ser_out_no | output | 1 | Serial data output, active low |

## Verification
The assertions rely on two conditions:
- `state_i` is stable in the cycle in which a synchronised latch edge is detected.
- The clear requests are levels in the system clock domain.

The stimulus changes the status word, the strobes and the extension bit only just after a falling system-clock edge. It holds each strobe level for several system cycles so that every edge passes the synchronisers cleanly. The extension bit changes together with the rising serial clock, so both pass through identical synchroniser depth and arrive in the same cycle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge
  import ssr_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter edge_e       KIND    = EDGE_RISE,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic pulse_o
);
  logic lvl, prev_q;

  ssr_sync #(.W(1), .STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign pulse_o = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse_o = ~lvl & prev_q;
    end
  endgenerate

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R3
endmodule

// File: rtl/ssr_shreg.sv
module ssr_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  output logic         msb_o
);
  logic [W-1:0] q;

  // clear > load > shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clr_i)   q <= '0;
    else if (load_i)  q <= par_i;
    else if (shift_i) q <= {q[W-2:0], ser_i};
  end

  assign msb_o = q[W-1];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q == '0)); // R7
  AST_LOAD_CAPTURES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (q == $past(par_i))); // R2
  AST_SHIFT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i && !clr_i) |=> (q == {$past(q[W-2:0]), $past(ser_i)})); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i && !clr_i) |=> $stable(q)); // R2
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
  import ssr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uv_i,
  input  logic             ext_rst_i,
  input  logic [WIDTH-1:0] state_i,
  input  logic             load_ni,
  input  logic             sclk_i,
  input  logic             ser_in_ni,
  output logic             ser_out_no
);
  logic clr, load_p, shift_p, sin_n_s, msb;

  assign clr = uv_i | ext_rst_i;

  ssr_edge #(.STAGES(SYNC_STAGES), .KIND(EDGE_FALL), .RST_VAL(1'b1)) u_load_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (load_ni),
    .pulse_o (load_p)
  );

  ssr_edge #(.STAGES(SYNC_STAGES), .KIND(EDGE_RISE), .RST_VAL(1'b0)) u_clk_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (sclk_i),
    .pulse_o (shift_p)
  );

  // same depth as the clock path keeps data aligned with its strobe
  ssr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ser_in_ni),
    .q_o    (sin_n_s)
  );

  ssr_shreg #(.W(WIDTH)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .load_i  (load_p),
    .shift_i (shift_p),
    .par_i   (state_i),
    .ser_i   (~sin_n_s),
    .msb_o   (msb)
  );

  assign ser_out_no = clr | ~msb;

  AST_LOAD_BEATS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_p && shift_p && !clr) |=>
      (uv_i || ext_rst_i || (ser_out_no == !$past(state_i[WIDTH-1])))); // R8
  AST_CLR_RELEASED_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !load_p && !shift_p) |=> ser_out_no); // R7
endmodule

// File: tb/serial_status_reg_tb.sv
module serial_status_reg_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, uv, ext, load_n, sclk, sin_n;
  logic [7:0] st_a, st_b;
  logic       out_a, out_b;
  int         n_chk = 0;
  int         n_bad = 0;

  serial_status_reg #(.WIDTH(8), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uv_i(uv), .ext_rst_i(ext), .state_i(st_a),
    .load_ni(load_n), .sclk_i(sclk), .ser_in_ni(sin_n), .ser_out_no(out_a)
  );

  serial_status_reg #(.WIDTH(8), .SYNC_STAGES(2)) u_nxt (
    .clk_i(clk), .rst_ni(rst_n), .uv_i(uv), .ext_rst_i(ext), .state_i(st_b),
    .load_ni(load_n), .sclk_i(sclk), .ser_in_ni(out_a), .ser_out_no(out_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_pulse();
    load_n = 1'b0; tick(4);
    load_n = 1'b1; tick(4);
  endtask

  task automatic shift_once();
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  task automatic read8(output logic [7:0] w);
    w = '0;
    for (int i = 0; i < 8; i++) begin
      w = {w[6:0], ~out_a};
      shift_once();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  w8, p;
    logic [23:0] wa, wb;
    rst_n = 1'b0; uv = 1'b0; ext = 1'b0; load_n = 1'b1; sclk = 1'b0; sin_n = 1'b1;
    st_a = '0; st_b = '0;
    tick(3);
    chk("R1 out in reset", 32'(out_a), 32'h1);
    rst_n = 1'b1; tick(4);
    chk("R1 out after reset", 32'(out_a), 32'h1);
    chk("R1 chain out after reset", 32'(out_b), 32'h1);
    read8(w8);
    chk("R1 empty after reset", 32'(w8), 32'h0);

    // R4 R5 R6: full sweep of the first device's word through a two-deep chain
    for (int v = 0; v < 256; v++) begin
      p = 8'(v * 29 + 1);
      st_a = 8'(v);
      st_b = 8'(v) ^ 8'hA5;
      load_pulse();
      wa = '0; wb = '0;
      for (int i = 0; i < 24; i++) begin
        wa = {wa[22:0], ~out_a};
        wb = {wb[22:0], ~out_b};
        sin_n = (i < 8) ? ~p[7-i] : 1'b1;
        shift_once();
      end
      sin_n = 1'b1;
      chk("R4 R5 single device order", 32'(wa), 32'({8'(v), p, 8'h00}));
      chk("R6 chained readout", 32'(wb), 32'({8'(v) ^ 8'hA5, 8'(v), p}));
    end

    // R2: rising latch edge has no effect
    st_a = 8'h5A; load_n = 1'b0; tick(4);
    st_a = 8'h3C; tick(2);
    load_n = 1'b1; tick(4);
    read8(w8);
    chk("R2 rising latch ignored", 32'(w8), 32'h5A);

    // R3: falling serial clock does not shift
    st_a = 8'hA0; load_pulse();
    chk("R3 first bit", 32'(out_a), 32'h0);
    sclk = 1'b1; tick(4);
    chk("R3 after rise", 32'(out_a), 32'h1);
    sclk = 1'b0; tick(4);
    chk("R3 after fall", 32'(out_a), 32'h1);
    sclk = 1'b1; tick(4);
    chk("R3 second rise", 32'(out_a), 32'h0);
    sclk = 1'b0; tick(4);

    // R7: undervoltage, then external clear
    for (int k = 0; k < 2; k++) begin
      st_a = 8'hFF; load_pulse();
      chk("R7 loaded before clear", 32'(out_a), 32'h0);
      if (k == 0) uv = 1'b1; else ext = 1'b1;
      tick(4);
      chk("R7 output released", 32'(out_a), 32'h1);
      load_pulse();
      shift_once();
      chk("R7 strobes ignored", 32'(out_a), 32'h1);
      uv = 1'b0; ext = 1'b0; tick(4);
      read8(w8);
      chk("R7 empty after clear", 32'(w8), 32'h0);
    end

    // R8: coincident latch and clock edges
    st_a = 8'h00; load_pulse();
    st_a = 8'hC3;
    load_n = 1'b0; sclk = 1'b1; tick(4);
    w8 = {7'h0, ~out_a};
    load_n = 1'b1; sclk = 1'b0; tick(4);
    for (int i = 1; i < 8; i++) begin
      shift_once();
      w8 = {w8[6:0], ~out_a};
    end
    chk("R8 load wins over shift", 32'(w8), 32'hC3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule